// File: doc/BRIEF.md
# 100BASE-TX Scrambler and MLT-3 Line Encoder

This block is the last digital stage of a fast-Ethernet transmit path. It takes 5-bit code-groups from the block encoder and sends them out one bit per bit clock, most significant bit first. Each serial bit is XORed with a keystream from an 11-bit linear feedback shift register. The result is converted first to NRZI and then to a three-level MLT-3 symbol. The output is a signed 2-bit level that an external line driver turns into the analog waveform.

Every code-group is scrambled the same way, with no exception for idle or the stream delimiters. The keystream generator is seeded from a 10-bit input while synchronous reset is held. A single-cycle `cg_take` strobe marks the clock in which the current `cg_in` value is taken, so the upstream encoder presents a new code-group every fifth clock.

Top module: `tx_line_encoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mlt` is 2'b00 (level 0) and `cg_take` is 1.
- R2: `cg_take` is high in the first cycle after reset and then exactly once every 5 clocks; `cg_in` is sampled only in those cycles.
- R3: A code-group is sent over 5 consecutive clocks in the order bit 4, 3, 2, 1, 0, starting in the cycle where `cg_take` is high.
- R4: The keystream bit is s[10] XOR s[8] of an 11-bit register s that shifts left by one each clock with that bit entering s[0]. Reset loads s = {1'b1, seed}, so s is never zero. The scrambled bit is the serial bit XOR the keystream bit.
- R5: All code-group values, including all-ones idle, are scrambled with no special case.
- R6: NRZI: a scrambled 1 toggles the NRZI level and a 0 holds it.
- R7: MLT-3 advances one step on each NRZI transition through the cycle 0, +1, 0, -1, starting at 0 after reset. The encoding is 2'b00 = 0, 2'b01 = +1 and 2'b11 = -1; 2'b10 never appears.
- R8: Output latency: the scrambled bit consumed at clock edge n changes `mlt` at edge n+1. After edge n, `mlt` reflects the count, modulo 4, of scrambled ones among bits 0..n-1.
- R9: `seed` is used only while `rst` is high; changes to it during operation do not affect the output.
- R10: A reset in the middle of a stream reloads the seed and restarts the serialiser, the NRZI level and the MLT-3 cycle, so the same seed and input repeat the same output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst | input | 1 | Synchronous active-high reset; loads the seed |
| seed | input | 10 | Scrambler seed, sampled during reset |
| cg_in | input | 5 | Code-group to transmit, held while `cg_take` is high |
| cg_take | output | 1 | High in the clock in which `cg_in` is taken |
| mlt | output | 2 | MLT-3 level: 00 = 0, 01 = +1, 11 = -1 |

## Verification
The assertions assume that `rst` is asserted from time zero for at least one edge, so the checker's phase counter and history start from a defined state. They also assume that `cg_in` is stable throughout each cycle in which `cg_take` is high, because the first bit of a group is passed straight through from the input. The bench drives `cg_in` and `seed` only on falling edges and holds each code-group for its whole five-clock slot. It moves `seed` in the middle of a stream only to show that the value is ignored outside reset.

// File: rtl/tx_enc_pkg.sv
package tx_enc_pkg;
  parameter int CG_W     = 5;   // code-group width
  parameter int LFSR_W   = 11;  // scrambler length (x^11)
  parameter int LFSR_TAP = 9;   // second tap (x^9)
  localparam int SEED_W  = LFSR_W - 1;

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [1:0]        mlt_t;
  typedef enum logic [1:0] {
    PH_ZERO_RISE = 2'd0,
    PH_POS       = 2'd1,
    PH_ZERO_FALL = 2'd2,
    PH_NEG       = 2'd3
  } mlt_phase_e;

  localparam mlt_t LVL_ZERO = 2'b00;
  localparam mlt_t LVL_POS  = 2'b01;
  localparam mlt_t LVL_NEG  = 2'b11;

  function automatic logic lfsr_fb(lfsr_t s);
    return s[LFSR_W-1] ^ s[LFSR_TAP-1];
  endfunction

  function automatic lfsr_t lfsr_next(lfsr_t s);
    return {s[LFSR_W-2:0], lfsr_fb(s)};
  endfunction

  function automatic lfsr_t lfsr_seed(logic [SEED_W-1:0] sd);
    return {1'b1, sd};
  endfunction

  function automatic mlt_phase_e mlt_advance(mlt_phase_e p);
    case (p)
      PH_ZERO_RISE: return PH_POS;
      PH_POS:       return PH_ZERO_FALL;
      PH_ZERO_FALL: return PH_NEG;
      default:      return PH_ZERO_RISE;
    endcase
  endfunction

  function automatic mlt_t mlt_level(mlt_phase_e p);
    case (p)
      PH_POS:  return LVL_POS;
      PH_NEG:  return LVL_NEG;
      default: return LVL_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/tx_ser.sv
module tx_ser
  import tx_enc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [CG_W-1:0] cg_in,
  output logic            take,
  output logic            bit_o
);
  localparam int CNT_W = $clog2(CG_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CG_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CG_W-1:0]  hold_q;

  assign take  = (cnt_q == '0);
  assign bit_o = take ? cg_in[CG_W-1] : hold_q[CG_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      hold_q <= take ? (cg_in << 1) : (hold_q << 1);
    end
  end
endmodule

// File: rtl/tx_scrambler.sv
module tx_scrambler
  import tx_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEED_W-1:0] seed,
  input  logic              in_bit,
  output logic              ks_bit,
  output logic              out_bit,
  output lfsr_t             state
);
  assign ks_bit  = lfsr_fb(state);
  assign out_bit = in_bit ^ ks_bit;

  always_ff @(posedge clk) begin
    if (rst) state <= lfsr_seed(seed);
    else     state <= lfsr_next(state);
  end
endmodule

// File: rtl/tx_mlt3.sv
module tx_mlt3
  import tx_enc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic nrz_bit,
  output logic nrzi_q,
  output logic nrzi_edge,
  output mlt_t level
);
  logic       nrzi_d;
  mlt_phase_e phase_q;

  assign nrzi_edge = nrzi_q ^ nrzi_d;
  assign level     = mlt_level(phase_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      nrzi_q  <= 1'b0;
      nrzi_d  <= 1'b0;
      phase_q <= PH_ZERO_RISE;
    end else begin
      nrzi_q  <= nrzi_q ^ nrz_bit;
      nrzi_d  <= nrzi_q;
      if (nrzi_edge) phase_q <= mlt_advance(phase_q);
    end
  end
endmodule

// File: rtl/tx_line_encoder.sv
module tx_line_encoder
  import tx_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEED_W-1:0] seed,
  input  logic [CG_W-1:0]   cg_in,
  output logic              cg_take,
  output logic [1:0]        mlt
);
  logic  ser_bit;
  logic  ks_bit;
  logic  scr_bit;
  logic  nrzi_q;
  logic  nrzi_edge;
  lfsr_t lfsr_q;

  tx_ser u_ser (
    .clk   (clk),
    .rst   (rst),
    .cg_in (cg_in),
    .take  (cg_take),
    .bit_o (ser_bit)
  );

  tx_scrambler u_scr (
    .clk     (clk),
    .rst     (rst),
    .seed    (seed),
    .in_bit  (ser_bit),
    .ks_bit  (ks_bit),
    .out_bit (scr_bit),
    .state   (lfsr_q)
  );

  tx_mlt3 u_mlt (
    .clk       (clk),
    .rst       (rst),
    .nrz_bit   (scr_bit),
    .nrzi_q    (nrzi_q),
    .nrzi_edge (nrzi_edge),
    .level     (mlt)
  );
endmodule

// File: rtl/tx_line_encoder_chk.sv
module tx_line_encoder_chk
  import tx_enc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        cg_take,
  input logic [1:0]  mlt,
  input logic        scr_bit,
  input logic        nrzi_q,
  input lfsr_t       lfsr_q
);
  logic       seen;
  logic [2:0] slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
      slot <= '0;
    end else begin
      seen <= 1'b1;
      slot <= (slot == 3'(CG_W - 1)) ? '0 : slot + 1'b1;
    end
  end

  p_take_period_r2: assert property (@(posedge clk) disable iff (rst)
    cg_take == (slot == '0));

  p_lfsr_live_r4: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);

  p_nrzi_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    seen |-> ((nrzi_q != $past(nrzi_q)) == $past(scr_bit)));

  p_legal_code_r7: assert property (@(posedge clk) disable iff (rst)
    mlt != 2'b10);

  p_one_step_r7: assert property (@(posedge clk) disable iff (rst)
    (seen && mlt != $past(mlt)) |-> (($past(mlt) == 2'b00) != (mlt == 2'b00)));

  p_follow_r8: assert property (@(posedge clk) disable iff (rst)
    (seen && nrzi_q != $past(nrzi_q)) |=> (mlt != $past(mlt)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (seen && nrzi_q == $past(nrzi_q)) |=> $stable(mlt));

  p_reload_r10: assert property (@(posedge clk) disable iff (rst)
    !seen |-> (lfsr_q[LFSR_W-1] && mlt == 2'b00 && cg_take));
endmodule

bind tx_line_encoder tx_line_encoder_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cg_take (cg_take),
  .mlt     (mlt),
  .scr_bit (scr_bit),
  .nrzi_q  (nrzi_q),
  .lfsr_q  (lfsr_q)
);

// File: tb/tb_tx_line_encoder.sv
module tb_tx_line_encoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] seed = '0;
  logic [4:0] cg_in = '0;
  logic       cg_take;
  logic [1:0] mlt;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  tx_line_encoder dut (
    .clk(clk), .rst(rst), .seed(seed), .cg_in(cg_in),
    .cg_take(cg_take), .mlt(mlt)
  );

  always #2 clk = ~clk;  // 250 MHz

  // expected level for a count of ones (R7 encoding)
  function automatic logic [1:0] lvl_of(int ones);
    case (ones % 4)
      1: return 2'b01;
      3: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [4:0] group_of(int mode, int g);
    case (mode)
      0: return 5'(g % 32);
      1: return 5'b11111;
      2: return 5'((g * 7 + 3) % 32);
      default: return (g % 2 == 1) ? 5'b10101 : 5'b00000;
    endcase
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // keystream as a recurrence y[n] = y[n-11] ^ y[n-9] (R4)
  task automatic run(logic [9:0] sd, int mode, int nbits, string tag);
    bit y [0:511];
    int ones = 0;
    @(negedge clk);
    rst  = 1'b1;
    seed = sd;
    cg_in = group_of(mode, 0);
    @(posedge clk);
    @(negedge clk);
    check("R1 reset level", mlt, 2'b00);
    check("R1 reset take", {1'b0, cg_take}, 2'b01);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) y[10 - i] = sd[i];
    y[0] = 1'b1;
    for (int n = 0; n < nbits; n++) begin
      logic [4:0] grp;
      bit b, k, s;
      grp = group_of(mode, n / 5);
      cg_in = grp;
      if (mode == 2 && n == nbits / 2) seed = ~sd;  // R9: ignored
      b = grp[4 - (n % 5)];
      k = y[n] ^ y[n + 2];
      y[n + 11] = k;
      s = b ^ k;
      check("R2 take", {1'b0, cg_take}, {1'b0, (n % 5 == 0)});
      @(posedge clk);
      @(negedge clk);
      check(tag, mlt, lvl_of(ones));
      ones += int'(s);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    run(10'h155, 0, 160, "R3 R6 R8 counting groups");
    run(10'h000, 1, 100, "R5 idle groups zero seed");
    run(10'h3FF, 3, 100, "R7 alternating groups");
    run(10'h2A3, 2, 100, "R9 seed moved mid-stream");
    run(10'h155, 0, 80,  "R10 restart after reset");
    for (int i = 0; i < 16; i++)
      run(10'(i * 68 + 1), 0, 60, "R4 seed sweep");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule